// File: doc/BRIEF.md
# Character-Protocol Command Exchange Sequencer

This block runs one command exchange with a smart card that uses the asynchronous half-duplex character protocol. When it is started, it clears the receive side of the UART. It then sends a fixed five-byte command header and reads the bytes the card returns. Each returned byte decides the next step:

- the sequencer keeps waiting;
- it moves every data byte still outstanding;
- it moves a single data byte;
- or it takes the byte as the first of two status bytes and ends the exchange after the second.

A direction input chooses the data path. In write mode the data is read from an external byte buffer and sent to the card. In read mode the bytes from the card are written into that buffer.

The receiver is switched off while the block transmits, so the line echo of sent bytes is never taken in. Each byte the block waits for is covered by an external waiting-time timer. If that timer expires, the exchange ends with a timeout error. The result is reported by a one-cycle done pulse, a 2-bit error code and the 16-bit status word.

Top module: `t0_tpdu_seq`

## Requirements
- R1: After reset the block is idle: `tx_valid`, `rx_en`, `rx_flush` and `done` are low and `err` is 0.
- R2: A `start` pulse while idle gives a one-cycle `rx_flush` pulse. The five header bytes follow in the order hdr[7:0], hdr[15:8], … hdr[39:32]. Byte 1 (hdr[15:8]) is the instruction code.
- R3: A received byte 0x60 moves no data and ends nothing; the block waits for another procedure byte.
- R4: A received byte whose upper nibble is 0x6 or 0x9, other than 0x60, is held as SW1. The next received byte is SW2. `done` then pulses for one cycle with `err`=0 and `sw`={SW1,SW2}.
- R5: A received byte equal to the instruction code moves all remaining data bytes, at buffer addresses from the current index up to `len`-1. The block then waits for a procedure byte again.
- R6: A received byte equal to the bitwise complement of the instruction code moves exactly one data byte. The block then waits for a procedure byte again.
- R7: Either acknowledge received when no data remains ends the exchange with `err`=2 (invalid).
- R8: Any other received procedure byte ends the exchange with `err`=2.
- R9: `wt_expired` high while a byte is awaited and none arrives ends the exchange with `err`=1 (timeout).
- R10: `start` is ignored while an exchange is in progress.
- R11: `rx_en` is low in every cycle in which `tx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (sampled when idle) |
| wr_dir | input | 1 | 1: data goes to the card, 0: data comes from the card |
| hdr | input | 40 | Command header, byte k at bits 8k+7:8k |
| len | input | LEN_W | Number of data bytes |
| tx_data | output | 8 | Byte to the UART transmitter |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | UART accepts the transmit byte |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | Received byte valid; taken when `rx_en` is high |
| rx_en | output | 1 | Receiver enabled, byte accepted |
| rx_flush | output | 1 | Pulse to discard pending received bytes |
| wt_expired | input | 1 | Waiting-time timer expired |
| buf_addr | output | LEN_W | Data buffer address |
| buf_rdata | input | 8 | Buffer read data for `buf_addr` (same cycle) |
| buf_wdata | output | 8 | Buffer write data |
| buf_we | output | 1 | Buffer write enable |
| done | output | 1 | One-cycle end-of-exchange pulse |
| err | output | 2 | 0 none, 1 timeout, 2 invalid data |
| sw | output | 16 | Status word {SW1,SW2} of the last successful exchange |

## Verification
The assertions assume three things about the inputs:
- a received byte is offered only through `rx_valid`;
- `wt_expired` is raised by a timer that runs only while `rx_en` is high;
- `buf_rdata` is a same-cycle read of `buf_addr`.

The stimulus follows these rules. The card model presents a byte only after it has seen `rx_en` high, and drops it at the next falling edge. Timer expiry is pulsed only while `rx_en` is high. The buffer model is a combinational array indexed by `buf_addr`.

// File: rtl/t0_pkg.sv
package t0_pkg;
  localparam int HDR_BYTES = 5;
  localparam int HIDX_W    = $clog2(HDR_BYTES);
  localparam logic [7:0] NULL_PB = 8'h60;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_INVALID = 2'd2
  } err_e;

  typedef enum logic [2:0] {
    PB_NULL,
    PB_SW1,
    PB_ACK_ALL,
    PB_ACK_ONE,
    PB_BAD
  } pb_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_HDR,
    ST_PROC,
    ST_DTX,
    ST_DRX,
    ST_SW2
  } state_e;
endpackage

// File: rtl/t0_pb_decode.sv
module t0_pb_decode
  import t0_pkg::*;
(
  input  logic [7:0] pb,
  input  logic [7:0] ins,
  output pb_kind_e   kind
);
  logic is_status;

  assign is_status = (pb[7:4] == 4'h6) || (pb[7:4] == 4'h9);

  always_comb begin
    if (pb == NULL_PB)        kind = PB_NULL;
    else if (is_status)       kind = PB_SW1;
    else if (pb == ins)       kind = PB_ACK_ALL;
    else if (pb == ~ins)      kind = PB_ACK_ONE;
    else                      kind = PB_BAD;
  end
endmodule

// File: rtl/t0_xfer_cnt.sv
module t0_xfer_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             step,
  output logic [LEN_W-1:0] idx,
  output logic             none_left,
  output logic             at_last
);
  logic [LEN_W-1:0] len_q, idx_q, idx_d, len_d;

  always_comb begin
    idx_d = idx_q;
    len_d = len_q;
    if (load) begin
      idx_d = '0;
      len_d = len;
    end else if (step) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      len_q <= '0;
    end else begin
      idx_q <= idx_d;
      len_q <= len_d;
    end
  end

  assign idx       = idx_q;
  assign none_left = (idx_q == len_q);
  assign at_last   = ((idx_q + 1'b1) == len_q);
endmodule

// File: rtl/t0_tpdu_seq.sv
module t0_tpdu_seq
  import t0_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_dir,
  input  logic [39:0]      hdr,
  input  logic [LEN_W-1:0] len,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             rx_en,
  output logic             rx_flush,
  input  logic             wt_expired,
  output logic [LEN_W-1:0] buf_addr,
  input  logic [7:0]       buf_rdata,
  output logic [7:0]       buf_wdata,
  output logic             buf_we,
  output logic             done,
  output logic [1:0]       err,
  output logic [15:0]      sw
);
  state_e                         state_q, state_d;
  logic [HDR_BYTES-1:0][7:0]      hdr_q, hdr_d;
  logic [HIDX_W-1:0]              hidx_q, hidx_d;
  logic                           dir_q, dir_d;
  logic                           one_q, one_d;
  logic [7:0]                     sw1_q, sw1_d;
  logic [15:0]                    sw_q, sw_d;
  err_e                           err_q, err_d;
  logic                           done_q, done_d;

  pb_kind_e         kind;
  logic             cnt_load, cnt_step, none_left, at_last;
  logic [LEN_W-1:0] idx;

  t0_pb_decode u_dec (
    .pb   (rx_data),
    .ins  (hdr_q[1]),
    .kind (kind)
  );

  t0_xfer_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_load),
    .len       (len),
    .step      (cnt_step),
    .idx       (idx),
    .none_left (none_left),
    .at_last   (at_last)
  );

  always_comb begin
    state_d  = state_q;
    hdr_d    = hdr_q;
    hidx_d   = hidx_q;
    dir_d    = dir_q;
    one_d    = one_q;
    sw1_d    = sw1_q;
    sw_d     = sw_q;
    err_d    = err_q;
    done_d   = 1'b0;
    cnt_load = 1'b0;
    cnt_step = 1'b0;
    tx_valid = 1'b0;
    tx_data  = hdr_q[hidx_q];
    rx_en    = 1'b0;
    rx_flush = 1'b0;
    buf_we   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_FLUSH;
          hdr_d    = hdr;
          dir_d    = wr_dir;
          hidx_d   = '0;
          err_d    = ERR_NONE;
          cnt_load = 1'b1;
        end
      end
      ST_FLUSH: begin
        rx_flush = 1'b1;
        state_d  = ST_HDR;
      end
      ST_HDR: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          if (hidx_q == HIDX_W'(HDR_BYTES - 1)) state_d = ST_PROC;
          else hidx_d = hidx_q + 1'b1;
        end
      end
      ST_PROC: begin
        rx_en = 1'b1;
        if (rx_valid) begin
          case (kind)
            PB_NULL: state_d = ST_PROC;
            PB_SW1: begin
              sw1_d   = rx_data;
              state_d = ST_SW2;
            end
            PB_ACK_ALL, PB_ACK_ONE: begin
              if (none_left) begin
                err_d   = ERR_INVALID;
                done_d  = 1'b1;
                state_d = ST_IDLE;
              end else begin
                one_d   = (kind == PB_ACK_ONE);
                state_d = dir_q ? ST_DTX : ST_DRX;
              end
            end
            default: begin
              err_d   = ERR_INVALID;
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end
          endcase
        end else if (wt_expired) begin
          err_d   = ERR_TIMEOUT;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_DTX: begin
        tx_valid = 1'b1;
        tx_data  = buf_rdata;
        if (tx_ready) begin
          cnt_step = 1'b1;
          if (one_q || at_last) state_d = ST_PROC;
        end
      end
      ST_DRX: begin
        rx_en = 1'b1;
        if (rx_valid) begin
          buf_we   = 1'b1;
          cnt_step = 1'b1;
          if (one_q || at_last) state_d = ST_PROC;
        end else if (wt_expired) begin
          err_d   = ERR_TIMEOUT;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SW2: begin
        rx_en = 1'b1;
        if (rx_valid) begin
          sw_d    = {sw1_q, rx_data};
          err_d   = ERR_NONE;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (wt_expired) begin
          err_d   = ERR_TIMEOUT;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      hidx_q  <= '0;
      dir_q   <= 1'b0;
      one_q   <= 1'b0;
      sw1_q   <= '0;
      sw_q    <= '0;
      err_q   <= ERR_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      hidx_q  <= hidx_d;
      dir_q   <= dir_d;
      one_q   <= one_d;
      sw1_q   <= sw1_d;
      sw_q    <= sw_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign buf_addr  = idx;
  assign buf_wdata = rx_data;
  assign done      = done_q;
  assign err       = err_q;
  assign sw        = sw_q;
endmodule

// File: rtl/t0_tpdu_seq_chk.sv
module t0_tpdu_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       rx_en,
  input logic       rx_valid,
  input logic       rx_flush,
  input logic       wt_expired,
  input logic       buf_we,
  input logic       done,
  input logic [1:0] err
);
  // R11
  rx_off_during_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_en);

  // R2
  hdr_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (tx_valid && !rx_flush));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rx_valid && wt_expired) |=> (done && err == 2'd1));

  // R5
  rx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (rx_en && rx_valid));

  // R8
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err != 2'd3);
endmodule

bind t0_tpdu_seq t0_tpdu_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .rx_en      (rx_en),
  .rx_valid   (rx_valid),
  .rx_flush   (rx_flush),
  .wt_expired (wt_expired),
  .buf_we     (buf_we),
  .done       (done),
  .err        (err)
);

// File: tb/t0_tpdu_seq_bench.sv
module t0_tpdu_seq_bench;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr_dir = 1'b0;
  logic [39:0] hdr = '0;
  logic [LEN_W-1:0] len = '0;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic rx_en, rx_flush;
  logic wt_expired = 1'b0;
  logic [LEN_W-1:0] buf_addr;
  logic [7:0] buf_rdata, buf_wdata;
  logic buf_we, done;
  logic [1:0] err;
  logic [15:0] sw;

  logic [7:0] mem [16];
  logic [7:0] tx_q [$];
  logic [15:0] wr_q [$];
  int checks = 0, fails = 0, cyc = 0;
  logic ready_tog = 1'b0;

  always #5 clk = ~clk;

  assign tx_ready  = ready_tog | tx_valid & buf_addr[0];
  assign buf_rdata = mem[buf_addr[3:0]];

  t0_tpdu_seq #(.LEN_W(LEN_W)) u_t0_tpdu_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_dir(wr_dir), .hdr(hdr), .len(len),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_en(rx_en), .rx_flush(rx_flush),
    .wt_expired(wt_expired), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .buf_wdata(buf_wdata), .buf_we(buf_we), .done(done), .err(err), .sw(sw)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    ready_tog <= ~ready_tog;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  // monitor: transmit and buffer-write scoreboards
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      chk(!rx_en, "R11", "rx_en during tx", {31'd0, rx_en}, 32'd0);
      if (tx_ready) begin
        if (tx_q.size() == 0)
          chk(1'b0, "R2", "unexpected tx byte", {24'd0, tx_data}, 32'hFFFF);
        else begin
          logic [7:0] e;
          e = tx_q.pop_front();
          chk(tx_data == e, "R2/R5", "tx byte", {24'd0, tx_data}, {24'd0, e});
        end
      end
    end
    if (rst_n && buf_we) begin
      if (wr_q.size() == 0)
        chk(1'b0, "R5", "unexpected buffer write", {16'd0, buf_addr, buf_wdata}, 32'hFFFF);
      else begin
        logic [15:0] e;
        e = wr_q.pop_front();
        chk({buf_addr, buf_wdata} == e, "R5/R6", "buffer write",
            {16'd0, buf_addr, buf_wdata}, {16'd0, e});
      end
    end
  end

  task automatic begin_xfer(input logic [39:0] h, input logic d, input int n);
    @(negedge clk);
    hdr = h; wr_dir = d; len = LEN_W'(n); start = 1'b1;
    for (int k = 0; k < 5; k++) tx_q.push_back(h[8*k +: 8]);
    @(negedge clk);
    start = 1'b0;
    chk(rx_flush == 1'b1, "R2", "flush pulse", {31'd0, rx_flush}, 32'd1);
  endtask

  task automatic wait_rx_en();
    for (int k = 0; k < 500; k++) begin
      if (rx_en) return;
      @(negedge clk);
    end
  endtask

  task automatic card(input logic [7:0] b);
    wait_rx_en();
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expire();
    wait_rx_en();
    wt_expired = 1'b1;
    @(negedge clk);
    wt_expired = 1'b0;
  endtask

  task automatic wait_done(input string req, input logic [1:0] e_err,
                           input bit chk_sw, input logic [15:0] e_sw);
    for (int k = 0; k < 500; k++) begin
      if (done) begin
        chk(err == e_err, req, "err", {30'd0, err}, {30'd0, e_err});
        if (chk_sw) chk(sw == e_sw, req, "status word", {16'd0, sw}, {16'd0, e_sw});
        chk(tx_q.size() == 0 && wr_q.size() == 0, req, "scoreboard drained",
            tx_q.size() + wr_q.size(), 0);
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
    chk(1'b0, req, "done not seen", 0, 1);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = 8'(8'hC0 + k);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !rx_en && !rx_flush && !done && err == 2'd0, "R1", "reset outputs",
        {27'd0, tx_valid, rx_en, rx_flush, done, 1'b0}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !rx_en && !done, "R1", "idle after release",
        {29'd0, tx_valid, rx_en, done}, 0);

    // write, null byte, INS ack with all data, status 90 00 (R2 R3 R4 R5)
    mem[0] = 8'h3F; mem[1] = 8'h00;
    begin_xfer({8'h02, 8'h00, 8'h00, 8'hA4, 8'hA0}, 1'b1, 2);
    tx_q.push_back(8'h3F); tx_q.push_back(8'h00);
    card(8'h60);
    chk(!done && rx_en && !tx_valid, "R3", "null byte keeps waiting",
        {29'd0, done, rx_en, tx_valid}, 32'b010);
    card(8'hA4);
    card(8'h90);
    card(8'h00);
    wait_done("R4", 2'd0, 1'b1, 16'h9000);

    // read, single ack then all ack, status 91 0F (R6 R5 R4)
    begin_xfer({8'h03, 8'h00, 8'h00, 8'hB0, 8'hA0}, 1'b0, 3);
    card(8'h4F);
    wr_q.push_back({8'd0, 8'h11}); card(8'h11);
    card(8'hB0);
    wr_q.push_back({8'd1, 8'h22}); card(8'h22);
    wr_q.push_back({8'd2, 8'h33}); card(8'h33);
    card(8'h91);
    card(8'h0F);
    wait_done("R6", 2'd0, 1'b1, 16'h910F);

    // write, single acks byte by byte, status 6C 10 (R6 R4)
    mem[0] = 8'h5A; mem[1] = 8'hA5;
    begin_xfer({8'h02, 8'h01, 8'h00, 8'hD6, 8'hA0}, 1'b1, 2);
    tx_q.push_back(8'h5A); card(8'h29);
    tx_q.push_back(8'hA5); card(8'h29);
    card(8'h6C);
    card(8'h10);
    wait_done("R4", 2'd0, 1'b1, 16'h6C10);

    // ack with no data (R7), sw unchanged
    begin_xfer({8'h00, 8'h00, 8'h00, 8'hA4, 8'hA0}, 1'b1, 0);
    card(8'hA4);
    wait_done("R7", 2'd2, 1'b1, 16'h6C10);

    // complement ack after data exhausted (R7)
    begin_xfer({8'h01, 8'h00, 8'h00, 8'hB0, 8'hA0}, 1'b0, 1);
    wr_q.push_back({8'd0, 8'h77});
    card(8'hB0); card(8'h77);
    card(8'h4F);
    wait_done("R7", 2'd2, 1'b0, 16'h0);

    // unexpected procedure byte (R8)
    begin_xfer({8'h02, 8'h00, 8'h00, 8'hA4, 8'hA0}, 1'b1, 2);
    card(8'h12);
    wait_done("R8", 2'd2, 1'b0, 16'h0);

    // timeout on procedure byte (R9)
    begin_xfer({8'h02, 8'h00, 8'h00, 8'hA4, 8'hA0}, 1'b1, 2);
    card(8'h60);
    expire();
    wait_done("R9", 2'd1, 1'b0, 16'h0);

    // timeout during data reception (R9)
    begin_xfer({8'h02, 8'h00, 8'h00, 8'hB0, 8'hA0}, 1'b0, 2);
    wr_q.push_back({8'd0, 8'h44});
    card(8'hB0); card(8'h44);
    expire();
    wait_done("R9", 2'd1, 1'b0, 16'h0);

    // start while busy is ignored (R10)
    begin_xfer({8'h00, 8'h00, 8'h00, 8'hF2, 8'h80}, 1'b1, 0);
    @(negedge clk);
    hdr = 40'hEEEEEEEEEE; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    card(8'h90);
    card(8'h01);
    wait_done("R10", 2'd0, 1'b1, 16'h9001);
    repeat (5) @(negedge clk);
    chk(!tx_valid && !rx_en, "R10", "idle after ignored start",
        {30'd0, tx_valid, rx_en}, 0);

    finish_run();
  end
endmodule